// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 64K x 16 dynamic RAM that supports fast page mode. The host issues one word request at a time. Each request has a 16-bit word address, write data, a two-bit byte-lane mask and a read/write flag, with a valid/ready handshake. The controller sends the upper address bits as the row and the lower bits as the column over a shared 8-bit address bus. It places each strobe edge on a whole-cycle boundary, so that the minimum precharge, row-to-column and column pulse times are met. These limits are given in nanoseconds and rounded up to clock cycles from the clock frequency parameter. Each request ends with a one-cycle response pulse, which carries the read data on a read.

After an access the row stays open, with RAS held low. A later request to the same row goes straight to a column cycle. A request to a different row first closes the open row and precharges. The two column strobes act as byte-lane selects: one for the upper byte and one for the lower byte. A free-running timer raises a refresh request about every 15.6 us. That request is served before any new host request. The refresh closes any open row and runs a cycle in which CAS falls before RAS, so the memory supplies the refresh row itself.

Top module: `fpmDramCtl`

## Requirements
- R1: The row (address bits 15..8) is on the address pins when RAS falls, and the column (bits 7..0) is on them when a column strobe falls with RAS low. In both cases the address has been stable for at least one cycle before the strobe edge.
- R2: Byte-enable bit 1 drives the upper column strobe (data bits 15..8) and bit 0 drives the lower one (bits 7..0). A write changes only the enabled bytes. On a read, a byte that is not enabled is returned as zero.
- R3: A request whose row equals the open row is served with no new row activation (no RAS falling edge).
- R4: A request to another row closes the open row. RAS then stays high for at least the precharge time in cycles before it falls again.
- R5: A column strobe falls no earlier than the RAS-to-CAS delay in cycles after RAS falls.
- R6: Refresh cycles drive both column strobes low before RAS falls, with WE held high. When the controller is idle, successive refreshes are exactly floor(CLK_MHZ*REF_NS/1000) cycles apart (3120 at the defaults).
- R7: A due refresh is served before any host request and closes the open row. The first request after a refresh therefore opens its row again.
- R8: The data bus drive enable is active only while WE is low and OE is high, that is, during write column cycles.
- R9: A request with byte enable 00 is accepted and answered with a response pulse. It produces no column strobe and leaves memory unchanged.
- R10: During reset, RAS, both column strobes, WE and OE are high, the bus drive enable is low and no response is pending. After reset, ready is high.
- R11: A read returns the data last written to that address, through the response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address, row in bits 15..8, column in bits 7..0 |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| rspValid | output | 1 | One-cycle pulse when a request completes |
| rspRdata | output | 16 | Read data, valid with rspValid on reads |
| dramRasN | output | 1 | Row address strobe, active low |
| dramCasN | output | 2 | Column strobes, bit 1 upper byte, bit 0 lower byte, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | 8 | Multiplexed row/column address |
| dramDqOut | output | 16 | Data driven toward the memory |
| dramDqOe | output | 1 | Tristate enable for dramDqOut |
| dramDqIn | input | 16 | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a refresh that becomes due while a row is open. The stimulus first reads from a row so that the row stays open. It then idles, watching a behavioural memory model for a RAS fall with a column strobe already low. Right after that refresh it reads the same address and requires one new activation, which shows that the refresh closed the row. The same model counts activations and column strobes for each request, which separates page hits from misses and shows that the zero-byte-enable request makes no strobe. Two further idle refreshes are timed against the computed interval.

// File: rtl/fpmDramPkg.sv
package fpmDramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PAGE_WAIT,
    ST_PRECHARGE,
    ST_REFRESH
  } ctlState_e;

  // Strobes from the control to the datapath, registered onto the pins
  typedef struct packed {
    logic loadReq;   // capture host request fields
    logic rasOn;     // RAS asserted
    logic colSel;    // column address on the pins
    logic casOn;     // column strobes for enabled lanes
    logic refCas;    // all column strobes (refresh)
    logic weOn;      // write enable asserted
    logic oeOn;      // output enable asserted
    logic dqDrive;   // drive the data bus
    logic finish;    // request done: capture read data, pulse response
  } ctlStrobe_t;

  function automatic int nsToCycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/fpmCtlFsm.sv
module fpmCtlFsm
  import fpmDramPkg::*;
#(
  parameter int RP_CYC   = 8,
  parameter int RCD_CYC  = 4,
  parameter int CAS_CYC  = 3,
  parameter int CP_CYC   = 2,
  parameter int CSR_CYC  = 2,
  parameter int RREF_CYC = 13,
  parameter int REF_CYC  = 3120
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  input  logic       curWrite,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  localparam int REFRESH_LEN = CSR_CYC + RREF_CYC;
  localparam int MAX_A = (RP_CYC > RCD_CYC) ? RP_CYC : RCD_CYC;
  localparam int MAX_B = (CAS_CYC > CP_CYC) ? CAS_CYC : CP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXC  = (MAX_C > REFRESH_LEN) ? MAX_C : REFRESH_LEN;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int REF_W = $clog2(REF_CYC + 1);

  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(RCD_CYC);
  localparam logic [CNT_W-1:0] LD_CAS  = CNT_W'(CAS_CYC);
  localparam logic [CNT_W-1:0] LD_CP   = CNT_W'(CP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REF  = CNT_W'(REFRESH_LEN - 1);
  localparam logic [CNT_W-1:0] RREF_LIM = CNT_W'(RREF_CYC);
  localparam logic [REF_W-1:0] REF_LD  = REF_W'(REF_CYC - 1);

  ctlState_e        state, nState;
  ctlState_e        pchNext, nPchNext;
  logic [CNT_W-1:0] waitCnt, nCnt;
  logic             rowOpen, nRowOpen;
  logic             refPending;
  logic [REF_W-1:0] refCnt;
  logic             refTake;

  assign reqReady = (state == ST_IDLE) && !refPending;

  // Next-state and timer logic
  always_comb begin
    nState   = state;
    nPchNext = pchNext;
    nRowOpen = rowOpen;
    nCnt     = (waitCnt != '0) ? waitCnt - 1'b1 : '0;
    refTake  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (refPending) begin
          nState   = ST_PRECHARGE;
          nCnt     = LD_RP;
          nPchNext = ST_REFRESH;
          nRowOpen = 1'b0;
        end else if (reqValid) begin
          if (rowOpen && rowHit) begin
            nState = ST_COL;
            nCnt   = LD_CAS;
          end else if (rowOpen) begin
            nState   = ST_PRECHARGE;
            nCnt     = LD_RP;
            nPchNext = ST_ROW;
            nRowOpen = 1'b0;
          end else begin
            nState = ST_ROW;
            nCnt   = LD_RCD;
          end
        end
      end
      ST_ROW: begin
        if (waitCnt == '0) begin
          nState = ST_COL;
          nCnt   = LD_CAS;
        end
      end
      ST_COL: begin
        if (waitCnt == '0) begin
          nState = ST_PAGE_WAIT;
          nCnt   = LD_CP;
        end
      end
      ST_PAGE_WAIT: begin
        if (waitCnt == '0) begin
          nState   = ST_IDLE;
          nRowOpen = 1'b1;
        end
      end
      ST_PRECHARGE: begin
        if (waitCnt == '0) begin
          nState = pchNext;
          if (pchNext == ST_ROW) begin
            nCnt = LD_RCD;
          end else if (pchNext == ST_REFRESH) begin
            nCnt    = LD_REF;
            refTake = 1'b1;
          end else begin
            nCnt = '0;
          end
        end
      end
      ST_REFRESH: begin
        if (waitCnt == '0) begin
          nState   = ST_PRECHARGE;
          nCnt     = LD_RP;
          nPchNext = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  // Strobe decode per state
  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        strobe.rasOn   = rowOpen;
        strobe.loadReq = reqValid && reqReady;
      end
      ST_ROW: begin
        strobe.rasOn = (waitCnt != LD_RCD);
      end
      ST_COL: begin
        strobe.rasOn   = 1'b1;
        strobe.colSel  = 1'b1;
        strobe.casOn   = (waitCnt != LD_CAS);
        strobe.weOn    = curWrite;
        strobe.oeOn    = !curWrite;
        strobe.dqDrive = curWrite;
      end
      ST_PAGE_WAIT: begin
        strobe.rasOn  = 1'b1;
        strobe.colSel = 1'b1;
        strobe.finish = (waitCnt == LD_CP);
      end
      ST_REFRESH: begin
        strobe.refCas = 1'b1;
        strobe.rasOn  = (waitCnt < RREF_LIM);
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pchNext <= ST_IDLE;
      waitCnt <= '0;
      rowOpen <= 1'b0;
    end else begin
      state   <= nState;
      pchNext <= nPchNext;
      waitCnt <= nCnt;
      rowOpen <= nRowOpen;
    end
  end

  // Refresh interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= REF_LD;
      refPending <= 1'b0;
    end else begin
      if (refCnt == '0) begin
        refCnt     <= REF_LD;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt - 1'b1;
        if (refTake) refPending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fpmDataPath.sv
module fpmDataPath
  import fpmDramPkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int MUX_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [LANES-1:0]       reqBe,
  input  logic [DATA_W-1:0]      dramDqIn,
  output logic                   rowHit,
  output logic                   curWrite,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspRdata,
  output logic                   dramRasN,
  output logic [LANES-1:0]       dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [MUX_W-1:0]       dramAddr,
  output logic [DATA_W-1:0]      dramDqOut,
  output logic                   dramDqOe
);

  localparam int ADDR_W = ROW_W + COL_W;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic [LANES-1:0]  curBe;
  logic [MUX_W-1:0]  rowPad, colPad;

  assign rowHit = (reqAddr[ADDR_W-1:COL_W] == curAddr[ADDR_W-1:COL_W]);

  always_comb begin
    rowPad = '0;
    colPad = '0;
    rowPad[ROW_W-1:0] = curAddr[ADDR_W-1:COL_W];
    colPad[COL_W-1:0] = curAddr[COL_W-1:0];
  end

  // Request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curBe    <= '0;
      curWrite <= 1'b0;
    end else if (strobe.loadReq) begin
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curBe    <= reqBe;
      curWrite <= reqWrite;
    end
  end

  // Shared pin registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dramRasN  <= 1'b1;
      dramWeN   <= 1'b1;
      dramOeN   <= 1'b1;
      dramAddr  <= '0;
      dramDqOut <= '0;
      dramDqOe  <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      dramRasN  <= !strobe.rasOn;
      dramWeN   <= !strobe.weOn;
      dramOeN   <= !strobe.oeOn;
      dramAddr  <= strobe.colSel ? colPad : rowPad;
      dramDqOut <= curWdata;
      dramDqOe  <= strobe.dqDrive;
      rspValid  <= strobe.finish;
    end
  end

  // Per-lane column strobes and read capture
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dramCasN[g]          <= 1'b1;
        rspRdata[g*8 +: 8]   <= '0;
      end else begin
        dramCasN[g] <= !((strobe.casOn && curBe[g]) || strobe.refCas);
        if (strobe.finish && !curWrite)
          rspRdata[g*8 +: 8] <= curBe[g] ? dramDqIn[g*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/fpmDramCtl.sv
module fpmDramCtl
  import fpmDramPkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int T_RP_NS   = 40,
  parameter int T_RCD_NS  = 20,
  parameter int T_CAS_NS  = 12,
  parameter int T_CP_NS   = 10,
  parameter int T_CSR_NS  = 10,
  parameter int T_RREF_NS = 65,
  parameter int REF_NS    = 15600
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqBe,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspRdata,
  output logic                   dramRasN,
  output logic [DATA_W/8-1:0]    dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]      dramDqOut,
  output logic                   dramDqOe,
  input  logic [DATA_W-1:0]      dramDqIn
);

  localparam int LANES    = DATA_W / 8;
  localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RP_CYC   = nsToCycles(T_RP_NS, CLK_MHZ);
  localparam int RCD_CYC  = nsToCycles(T_RCD_NS, CLK_MHZ);
  localparam int CAS_CYC  = nsToCycles(T_CAS_NS, CLK_MHZ);
  localparam int CP_CYC   = nsToCycles(T_CP_NS, CLK_MHZ);
  localparam int CSR_CYC  = nsToCycles(T_CSR_NS, CLK_MHZ);
  localparam int RREF_CYC = nsToCycles(T_RREF_NS, CLK_MHZ);
  localparam int REF_CYC  = CLK_MHZ * REF_NS / 1000;

  ctlStrobe_t strobe;
  logic       rowHit;
  logic       curWrite;

  fpmCtlFsm #(
    .RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC),
    .CP_CYC(CP_CYC), .CSR_CYC(CSR_CYC), .RREF_CYC(RREF_CYC),
    .REF_CYC(REF_CYC)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rowHit   (rowHit),
    .curWrite (curWrite),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  fpmDataPath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .LANES(LANES), .MUX_W(MUX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqBe     (reqBe),
    .dramDqIn  (dramDqIn),
    .rowHit    (rowHit),
    .curWrite  (curWrite),
    .rspValid  (rspValid),
    .rspRdata  (rspRdata),
    .dramRasN  (dramRasN),
    .dramCasN  (dramCasN),
    .dramWeN   (dramWeN),
    .dramOeN   (dramOeN),
    .dramAddr  (dramAddr),
    .dramDqOut (dramDqOut),
    .dramDqOe  (dramDqOe)
  );

endmodule

// File: rtl/fpmDramCtlChk.sv
module fpmDramCtlChk #(
  parameter int MIN_RP  = 1,
  parameter int MIN_RCD = 1,
  parameter int LANES   = 2,
  parameter int MUX_W   = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dramRasN,
  input logic [LANES-1:0] dramCasN,
  input logic             dramWeN,
  input logic             dramOeN,
  input logic [MUX_W-1:0] dramAddr,
  input logic             dramDqOe
);

  localparam int BIG  = (MIN_RP > MIN_RCD) ? MIN_RP : MIN_RCD;
  localparam int CW   = $clog2(BIG + 2);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] highCnt, lowCnt;
  logic          casLow;

  assign casLow = (dramCasN != '1);

  // Consecutive cycles with RAS high / low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= CW'(MIN_RP);
      lowCnt  <= '0;
    end else begin
      if (dramRasN) begin
        if (highCnt != SAT) highCnt <= highCnt + 1'b1;
        lowCnt <= '0;
      end else begin
        if (lowCnt != SAT) lowCnt <= lowCnt + 1'b1;
        highCnt <= '0;
      end
    end
  end

  a_r1_row_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && !casLow) |-> $stable(dramAddr));

  a_r1_col_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(casLow) && !dramRasN) |-> $stable(dramAddr));

  a_r4_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (highCnt >= CW'(MIN_RP)));

  a_r5_ras_to_cas: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(casLow) && !dramRasN) |-> (lowCnt >= CW'(MIN_RCD)));

  a_r6_cbr_form: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && casLow) |-> (dramWeN && (dramCasN == '0)));

  a_r8_drive_write: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> (!dramWeN && dramOeN));

endmodule

bind fpmDramCtl fpmDramCtlChk #(
  .MIN_RP(RP_CYC), .MIN_RCD(RCD_CYC), .LANES(LANES), .MUX_W(MUX_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .dramRasN (dramRasN),
  .dramCasN (dramCasN),
  .dramWeN  (dramWeN),
  .dramOeN  (dramOeN),
  .dramAddr (dramAddr),
  .dramDqOe (dramDqOe)
);

// File: tb/fpmDramCtl_tb_top.sv
module fpmDramCtl_tb_top;

  localparam int REF_EXPECT = 200 * 15600 / 1000;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 15;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic [15:0] exp;
    logic [1:0]  acts;
    logic        casEv;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'h1203, 16'hA5C3, 2'b11, 16'h0000, 2'd1, 1'b1},
    '{1'b0, 16'h1203, 16'h0000, 2'b11, 16'hA5C3, 2'd0, 1'b1},
    '{1'b1, 16'h1210, 16'h1111, 2'b01, 16'h0000, 2'd0, 1'b1},
    '{1'b1, 16'h1210, 16'hBE22, 2'b10, 16'h0000, 2'd0, 1'b1},
    '{1'b0, 16'h1210, 16'h0000, 2'b11, 16'hBE11, 2'd0, 1'b1},
    '{1'b0, 16'h1210, 16'h0000, 2'b01, 16'h0011, 2'd0, 1'b1},
    '{1'b0, 16'h1210, 16'h0000, 2'b10, 16'hBE00, 2'd0, 1'b1},
    '{1'b1, 16'h3403, 16'h7777, 2'b11, 16'h0000, 2'd1, 1'b1},
    '{1'b0, 16'h1203, 16'h0000, 2'b11, 16'hA5C3, 2'd1, 1'b1},
    '{1'b0, 16'h3403, 16'h0000, 2'b11, 16'h7777, 2'd1, 1'b1},
    '{1'b1, 16'h3403, 16'hFFFF, 2'b00, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 16'h3403, 16'h0000, 2'b11, 16'h7777, 2'd0, 1'b1},
    '{1'b1, 16'hFFFF, 16'h0102, 2'b11, 16'h0000, 2'd1, 1'b1},
    '{1'b0, 16'h00FF, 16'h0000, 2'b11, 16'h0000, 2'd1, 1'b1},
    '{1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'h0102, 2'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic        dramRasN;
  logic [1:0]  dramCasN;
  logic        dramWeN;
  logic        dramOeN;
  logic [7:0]  dramAddr;
  logic [15:0] dramDqOut;
  logic        dramDqOe;
  logic [15:0] dramDqIn;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  always #2.5ns clk = ~clk;

  fpmDramCtl dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  // Behavioural memory model, sampled between clock edges
  logic [15:0] mem [int];
  logic        prevRasN = 1'b1;
  logic        prevCasLow = 1'b0;
  logic [7:0]  mRow = '0;
  logic [7:0]  mCol = '0;
  logic [15:0] readWord = '0;
  int          actCount = 0;
  int          casEvCount = 0;
  int          refCount = 0;
  int          refCycle [$];

  assign dramDqIn[15:8] = (!dramRasN && !dramCasN[1] && !dramOeN && dramWeN) ? readWord[15:8] : 8'hzz;
  assign dramDqIn[7:0]  = (!dramRasN && !dramCasN[0] && !dramOeN && dramWeN) ? readWord[7:0]  : 8'hzz;

  always @(negedge clk) begin
    logic casLowNow;
    int   key;
    logic [15:0] w;
    cycle = cycle + 1;
    casLowNow = (dramCasN != 2'b11);
    if (rstN) begin
      if (prevRasN && !dramRasN) begin
        if (casLowNow) begin
          refCount = refCount + 1;
          refCycle.push_back(cycle);
        end else begin
          actCount = actCount + 1;
          mRow = dramAddr;
        end
      end
      if (!dramRasN && !prevRasN && casLowNow && !prevCasLow) begin
        casEvCount = casEvCount + 1;
        mCol = dramAddr;
        key  = {16'h0, mRow, mCol};
        w    = mem.exists(key) ? mem[key] : 16'h0000;
        if (!dramWeN && dramDqOe) begin
          if (!dramCasN[1]) w[15:8] = dramDqOut[15:8];
          if (!dramCasN[0]) w[7:0]  = dramDqOut[7:0];
          mem[key] = w;
        end
        readWord = w;
      end
    end
    prevRasN   = dramRasN;
    prevCasLow = casLowNow;
    if (cycle == WATCHDOG) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cycle, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                          input logic [1:0] be, output logic [15:0] rd, output logic gotRsp);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata; reqBe = be;
    n = 0;
    while (!reqReady && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 200) begin @(negedge clk); n++; end
    gotRsp = rspValid;
    rd = rspRdata;
  endtask

  initial begin
    logic [15:0] rd;
    logic        got;
    int          a0, c0, r0, n;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(dramRasN && dramCasN == 2'b11 && dramWeN && dramOeN, "R10 strobes high in reset",
          {28'h0, dramRasN, dramCasN, dramWeN}, 32'hF);
    check(!dramDqOe && !rspValid, "R10 bus and response idle in reset",
          {30'h0, dramDqOe, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R10 ready after reset", {31'h0, reqReady}, 32'h1);

    // Vector table: R1 R2 R3 R4 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      a0 = actCount; c0 = casEvCount;
      doAccess(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd, got);
      check(got, "R9 R11 response pulse", {31'h0, got}, 32'h1);
      if (!VECS[i].wr)
        check(rd == VECS[i].exp, "R2 R11 read data", {16'h0, rd}, {16'h0, VECS[i].exp});
      check(actCount - a0 == int'(VECS[i].acts), "R3 R4 row activations",
            actCount - a0, {30'h0, VECS[i].acts});
      check(casEvCount - c0 == int'(VECS[i].casEv), "R2 R9 column strobe events",
            casEvCount - c0, {31'h0, VECS[i].casEv});
      if (VECS[i].be != 2'b00)
        check({mRow, mCol} == VECS[i].addr, "R1 row and column on address pins",
              {16'h0, mRow, mCol}, {16'h0, VECS[i].addr});
    end

    // R7: refresh while a row is open closes it
    doAccess(1'b0, 16'h1203, 16'h0, 2'b11, rd, got);
    check(rd == 16'hA5C3, "R11 read before refresh", {16'h0, rd}, 32'hA5C3);
    r0 = refCount;
    n = 0;
    while (refCount == r0 && n < 4000) begin @(negedge clk); n++; end
    check(refCount == r0 + 1, "R6 refresh issued", refCount, r0 + 1);
    a0 = actCount;
    doAccess(1'b0, 16'h1203, 16'h0, 2'b11, rd, got);
    check(actCount - a0 == 1, "R7 row reopened after refresh", actCount - a0, 32'd1);
    check(rd == 16'hA5C3, "R11 data kept across refresh", {16'h0, rd}, 32'hA5C3);

    // R6: idle refresh interval
    r0 = refCount;
    n = 0;
    while (refCount < r0 + 2 && n < 8000) begin @(negedge clk); n++; end
    check(refCount == r0 + 2, "R6 two idle refreshes", refCount, r0 + 2);
    if (refCycle.size() >= 2)
      check(refCycle[$] - refCycle[$-1] == REF_EXPECT, "R6 refresh interval",
            refCycle[$] - refCycle[$-1], REF_EXPECT);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule